// File: doc/BRIEF.md
# Pixel-Clock Display Timing Generator

This block produces the horizontal sync, vertical sync, data-enable, display-window, active-window and data-valid strobes for a video panel. It runs on the pixel clock and takes its timing from a small set of registers written through a single-cycle write port. Horizontal timing is expressed in columns within a line. Vertical timing is not expressed as line numbers. Every vertical bound is an absolute pixel-clock position inside the frame: lines times line period, plus any sync skew. A single in-frame position counter is compared directly against those bounds.

Timing registers are double-buffered. A write lands in a pending copy. The working copy is refreshed from it on the first pixel of the next frame, or continuously while the engine is disabled. The two counter-control registers act at once. The block also reports a frame counter and a line-in-frame counter. Counting is gated by a two-bit enable, and a write can clear both counters synchronously.

Top module: `disp_tgen`

## Requirements
- R1: Register 0 holds the line period in bits 31:16 and the HSYNC width in bits 15:0. The column counter runs from 0 to period−1, and HSYNC is active for columns below the width.
- R2: Register 1 holds the frame length in pixel clocks and register 2 holds the VSYNC length in pixel clocks. The in-frame position wraps to 0 after frame length−1, and VSYNC is active while the position is below the VSYNC length.
- R3: The display window is active when the column lies within register 3 (end in bits 31:16, start in bits 15:0, both inclusive) and the position lies within register 4 (first) through register 5 (last), both inclusive.
- R4: The active window (act_win_o) uses register 6 for columns and registers 7 and 8 for positions, with the same encoding as R3. The data-enable output is the active window passed through its polarity bit.
- R5: Register 10 selects polarity. Bit 0 inverts HSYNC, bit 1 inverts VSYNC and bit 2 inverts data-enable.
- R6: When bit 0 of register 11 is set, data-valid is the active window restricted to the columns of register 9 (encoded as in R3). When the bit is clear, data-valid equals the active window.
- R7: When both bits 1:0 of register 12 are set, the frame counter increments on every frame wrap and the line counter counts completed lines in the current frame, returning to 0 at the wrap. Otherwise both counters hold.
- R8: A write to register 13 with bit 31 set clears both counters on that clock edge, taking priority over counting.
- R9: While the enable input is low, HSYNC, VSYNC and data-enable sit at their inactive levels, the windows are low, and both counters and the position read zero. Re-enabling restarts from position 0.
- R10: A write to registers 0 to 11 while running leaves the current frame unchanged. It takes effect from the first pixel of the next frame.
- R11: After reset, all outputs and counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timing engine enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register index |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| disp_win_o | output | 1 | Display window strobe |
| act_win_o | output | 1 | Active window strobe |
| data_vld_o | output | 1 | Data-valid window strobe |
| frame_cnt_o | output | 16 | Frame counter |
| line_cnt_o | output | 16 | Line counter within frame |

## Verification
A wrong position or column count shows at the sync outputs within one line, because HSYNC and window edges shift by the error. A wrong wrap point shows at VSYNC within one frame. A stale or early load of the working register copy shows at the first pixel after a frame boundary, where polarity or sync width would not match the pending value. Counter faults show at the counter outputs on the first line or frame edge after counting starts, and a failed clear shows on the very next cycle.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  localparam int unsigned COL_W  = 16;
  localparam int unsigned POS_W  = 24;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned NWIN   = 5;

  localparam int unsigned WIN_DISP_H = 0;
  localparam int unsigned WIN_DISP_V = 1;
  localparam int unsigned WIN_ACT_H  = 2;
  localparam int unsigned WIN_ACT_V  = 3;
  localparam int unsigned WIN_DAT_H  = 4;

  localparam int unsigned POL_HS = 0;
  localparam int unsigned POL_VS = 1;
  localparam int unsigned POL_DE = 2;

  localparam int unsigned CLR_BIT = DATA_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_HCTL      = 4'd0,
    REG_FRAME_LEN = 4'd1,
    REG_VS_LEN    = 4'd2,
    REG_DISP_H    = 4'd3,
    REG_DISP_VS   = 4'd4,
    REG_DISP_VE   = 4'd5,
    REG_ACT_H     = 4'd6,
    REG_ACT_VS    = 4'd7,
    REG_ACT_VE    = 4'd8,
    REG_DAT_H     = 4'd9,
    REG_POL       = 4'd10,
    REG_CFG       = 4'd11,
    REG_CNT_EN    = 4'd12,
    REG_CNT_CTL   = 4'd13
  } reg_e;

  typedef struct packed {
    logic [COL_W-1:0] line_len;
    logic [COL_W-1:0] hs_w;
    logic [COL_W-1:0] disp_hs;
    logic [COL_W-1:0] disp_he;
    logic [COL_W-1:0] act_hs;
    logic [COL_W-1:0] act_he;
    logic [COL_W-1:0] dat_hs;
    logic [COL_W-1:0] dat_he;
    logic [POS_W-1:0] frame_len;
    logic [POS_W-1:0] vs_len;
    logic [POS_W-1:0] disp_vs;
    logic [POS_W-1:0] disp_ve;
    logic [POS_W-1:0] act_vs;
    logic [POS_W-1:0] act_ve;
    logic [2:0]       pol;
    logic             dat_en;
  } timing_t;
endpackage

// File: rtl/tgen_regs.sv
module tgen_regs
  import tgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              frame_end_i,
  output timing_t           cfg_o,
  output logic              cnt_run_o,
  output logic              cnt_clr_o
);
  localparam int unsigned HI = 2 * COL_W - 1;

  timing_t    pend_q, act_q;
  logic [1:0] cnt_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      act_q    <= '0;
      cnt_en_q <= '0;
    end else begin
      if (wr_en_i) begin
        case (reg_e'(wr_addr_i))
          REG_HCTL: begin
            pend_q.line_len <= wr_data_i[HI:COL_W];
            pend_q.hs_w     <= wr_data_i[COL_W-1:0];
          end
          REG_FRAME_LEN: pend_q.frame_len <= wr_data_i[POS_W-1:0];
          REG_VS_LEN:    pend_q.vs_len    <= wr_data_i[POS_W-1:0];
          REG_DISP_H: begin
            pend_q.disp_he <= wr_data_i[HI:COL_W];
            pend_q.disp_hs <= wr_data_i[COL_W-1:0];
          end
          REG_DISP_VS: pend_q.disp_vs <= wr_data_i[POS_W-1:0];
          REG_DISP_VE: pend_q.disp_ve <= wr_data_i[POS_W-1:0];
          REG_ACT_H: begin
            pend_q.act_he <= wr_data_i[HI:COL_W];
            pend_q.act_hs <= wr_data_i[COL_W-1:0];
          end
          REG_ACT_VS: pend_q.act_vs <= wr_data_i[POS_W-1:0];
          REG_ACT_VE: pend_q.act_ve <= wr_data_i[POS_W-1:0];
          REG_DAT_H: begin
            pend_q.dat_he <= wr_data_i[HI:COL_W];
            pend_q.dat_hs <= wr_data_i[COL_W-1:0];
          end
          REG_POL:    pend_q.pol    <= wr_data_i[2:0];
          REG_CFG:    pend_q.dat_en <= wr_data_i[0];
          REG_CNT_EN: cnt_en_q      <= wr_data_i[1:0];
          default: ;
        endcase
      end
      // working copy only moves between frames
      if (!en_i || frame_end_i) act_q <= pend_q;
    end
  end

  assign cfg_o     = act_q;
  assign cnt_run_o = &cnt_en_q;
  assign cnt_clr_o = wr_en_i && (reg_e'(wr_addr_i) == REG_CNT_CTL) && wr_data_i[CLR_BIT];
endmodule

// File: rtl/tgen_counters.sv
module tgen_counters
  import tgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [COL_W-1:0] line_len_i,
  input  logic [POS_W-1:0] frame_len_i,
  input  logic             cnt_run_i,
  input  logic             cnt_clr_i,
  output logic [POS_W-1:0] pos_o,
  output logic [COL_W-1:0] col_o,
  output logic             frame_end_o,
  output logic [CNT_W-1:0] frame_cnt_o,
  output logic [CNT_W-1:0] line_cnt_o
);
  logic [POS_W-1:0] pos_q;
  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] fcnt_q, lcnt_q;
  logic             line_end;

  assign line_end    = (col_q == line_len_i - COL_W'(1));
  assign frame_end_o = en_i && (pos_q == frame_len_i - POS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      col_q  <= '0;
      fcnt_q <= '0;
      lcnt_q <= '0;
    end else if (!en_i) begin
      pos_q  <= '0;
      col_q  <= '0;
      fcnt_q <= '0;
      lcnt_q <= '0;
    end else begin
      pos_q <= frame_end_o ? '0 : pos_q + POS_W'(1);
      col_q <= (frame_end_o || line_end) ? '0 : col_q + COL_W'(1);
      if (cnt_clr_i) begin
        fcnt_q <= '0;
        lcnt_q <= '0;
      end else if (cnt_run_i) begin
        if (frame_end_o) begin
          fcnt_q <= fcnt_q + CNT_W'(1);
          lcnt_q <= '0;
        end else if (line_end) begin
          lcnt_q <= lcnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign pos_o       = pos_q;
  assign col_o       = col_q;
  assign frame_cnt_o = fcnt_q;
  assign line_cnt_o  = lcnt_q;
endmodule

// File: rtl/tgen_win.sv
module tgen_win #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         hit_o
);
  assign hit_o = (val_i >= lo_i) && (val_i <= hi_i);
endmodule

// File: rtl/disp_tgen.sv
module disp_tgen
  import tgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              disp_win_o,
  output logic              act_win_o,
  output logic              data_vld_o,
  output logic [CNT_W-1:0]  frame_cnt_o,
  output logic [CNT_W-1:0]  line_cnt_o
);
  timing_t          cfg;
  logic             cnt_run, cnt_clr, frame_end;
  logic [POS_W-1:0] pos_q;
  logic [COL_W-1:0] col_q;

  tgen_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .frame_end_i (frame_end),
    .cfg_o       (cfg),
    .cnt_run_o   (cnt_run),
    .cnt_clr_o   (cnt_clr)
  );

  tgen_counters u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .line_len_i  (cfg.line_len),
    .frame_len_i (cfg.frame_len),
    .cnt_run_i   (cnt_run),
    .cnt_clr_i   (cnt_clr),
    .pos_o       (pos_q),
    .col_o       (col_q),
    .frame_end_o (frame_end),
    .frame_cnt_o (frame_cnt_o),
    .line_cnt_o  (line_cnt_o)
  );

  logic [POS_W-1:0] w_val [NWIN];
  logic [POS_W-1:0] w_lo  [NWIN];
  logic [POS_W-1:0] w_hi  [NWIN];
  logic [NWIN-1:0]  w_hit;

  always_comb begin
    w_val[WIN_DISP_H] = POS_W'(col_q);
    w_lo[WIN_DISP_H]  = POS_W'(cfg.disp_hs);
    w_hi[WIN_DISP_H]  = POS_W'(cfg.disp_he);
    w_val[WIN_DISP_V] = pos_q;
    w_lo[WIN_DISP_V]  = cfg.disp_vs;
    w_hi[WIN_DISP_V]  = cfg.disp_ve;
    w_val[WIN_ACT_H]  = POS_W'(col_q);
    w_lo[WIN_ACT_H]   = POS_W'(cfg.act_hs);
    w_hi[WIN_ACT_H]   = POS_W'(cfg.act_he);
    w_val[WIN_ACT_V]  = pos_q;
    w_lo[WIN_ACT_V]   = cfg.act_vs;
    w_hi[WIN_ACT_V]   = cfg.act_ve;
    w_val[WIN_DAT_H]  = POS_W'(col_q);
    w_lo[WIN_DAT_H]   = POS_W'(cfg.dat_hs);
    w_hi[WIN_DAT_H]   = POS_W'(cfg.dat_he);
  end

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    tgen_win #(.W(POS_W)) u_win (
      .val_i (w_val[gi]),
      .lo_i  (w_lo[gi]),
      .hi_i  (w_hi[gi]),
      .hit_o (w_hit[gi])
    );
  end

  logic act_now;
  assign act_now = w_hit[WIN_ACT_H] & w_hit[WIN_ACT_V];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      de_o       <= 1'b0;
      disp_win_o <= 1'b0;
      act_win_o  <= 1'b0;
      data_vld_o <= 1'b0;
    end else if (!en_i) begin
      hsync_o    <= cfg.pol[POL_HS];
      vsync_o    <= cfg.pol[POL_VS];
      de_o       <= cfg.pol[POL_DE];
      disp_win_o <= 1'b0;
      act_win_o  <= 1'b0;
      data_vld_o <= 1'b0;
    end else begin
      hsync_o    <= (col_q < cfg.hs_w) ^ cfg.pol[POL_HS];
      vsync_o    <= (pos_q < cfg.vs_len) ^ cfg.pol[POL_VS];
      disp_win_o <= w_hit[WIN_DISP_H] & w_hit[WIN_DISP_V];
      act_win_o  <= act_now;
      de_o       <= act_now ^ cfg.pol[POL_DE];
      data_vld_o <= act_now & (~cfg.dat_en | w_hit[WIN_DAT_H]);
    end
  end
endmodule

// File: rtl/tgen_chk.sv
module tgen_chk
  import tgen_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             disp_win_o,
  input logic             act_win_o,
  input logic             data_vld_o,
  input logic [CNT_W-1:0] frame_cnt_o,
  input logic [CNT_W-1:0] line_cnt_o,
  input logic [POS_W-1:0] pos_i,
  input logic [POS_W-1:0] frame_len_i,
  input logic             cnt_run_i,
  input logic             cnt_clr_i
);
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> (!disp_win_o && !act_win_o && !data_vld_o &&
                      frame_cnt_o == '0 && line_cnt_o == '0));

  assert_dv_in_act_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> act_win_o);

  assert_pos_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_len_i != '0) |-> (pos_i < frame_len_i));

  assert_frame_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i && !cnt_clr_i) && frame_cnt_o != $past(frame_cnt_o))
      |-> frame_cnt_o == $past(frame_cnt_o) + CNT_W'(1));

  assert_line_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i && !cnt_clr_i) && line_cnt_o != $past(line_cnt_o))
      |-> (line_cnt_o == $past(line_cnt_o) + CNT_W'(1) || line_cnt_o == '0));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && !cnt_run_i && !cnt_clr_i)
      |-> (frame_cnt_o == $past(frame_cnt_o) && line_cnt_o == $past(line_cnt_o)));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cnt_clr_i) |-> (frame_cnt_o == '0 && line_cnt_o == '0));
endmodule

bind disp_tgen tgen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .disp_win_o  (disp_win_o),
  .act_win_o   (act_win_o),
  .data_vld_o  (data_vld_o),
  .frame_cnt_o (frame_cnt_o),
  .line_cnt_o  (line_cnt_o),
  .pos_i       (pos_q),
  .frame_len_i (cfg.frame_len),
  .cnt_run_i   (cnt_run),
  .cnt_clr_i   (cnt_clr)
);

// File: tb/tb_disp_tgen.sv
module tb_disp_tgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync_o, vsync_o, de_o, disp_win_o, act_win_o, data_vld_o;
  logic [15:0] frame_cnt_o, line_cnt_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    chk_on = 1'b0;
  string ctx = "";

  always #4 clk = ~clk;

  disp_tgen dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .disp_win_o(disp_win_o), .act_win_o(act_win_o), .data_vld_o(data_vld_o),
    .frame_cnt_o(frame_cnt_o), .line_cnt_o(line_cnt_o)
  );

  // reference model built from the requirements
  typedef struct {
    int ll, hs, fl, vsl, dhs, dhe, dvs, dve, ahs, ahe, avs, ave, ths, the, pol, den;
  } tcfg_t;

  tcfg_t pend, cur;
  int    mpos, mcol, mf, ml;
  bit    m_run;
  logic  e_hs, e_vs, e_de, e_disp, e_act, e_dv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '{default: 0};
      cur  <= '{default: 0};
      mpos <= 0; mcol <= 0; mf <= 0; ml <= 0; m_run <= 1'b0;
      e_hs <= 0; e_vs <= 0; e_de <= 0; e_disp <= 0; e_act <= 0; e_dv <= 0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          4'd0:  begin pend.ll <= int'(wr_data[31:16]); pend.hs <= int'(wr_data[15:0]); end
          4'd1:  pend.fl  <= int'(wr_data[23:0]);
          4'd2:  pend.vsl <= int'(wr_data[23:0]);
          4'd3:  begin pend.dhe <= int'(wr_data[31:16]); pend.dhs <= int'(wr_data[15:0]); end
          4'd4:  pend.dvs <= int'(wr_data[23:0]);
          4'd5:  pend.dve <= int'(wr_data[23:0]);
          4'd6:  begin pend.ahe <= int'(wr_data[31:16]); pend.ahs <= int'(wr_data[15:0]); end
          4'd7:  pend.avs <= int'(wr_data[23:0]);
          4'd8:  pend.ave <= int'(wr_data[23:0]);
          4'd9:  begin pend.the <= int'(wr_data[31:16]); pend.ths <= int'(wr_data[15:0]); end
          4'd10: pend.pol <= int'(wr_data[2:0]);
          4'd11: pend.den <= int'(wr_data[0]);
          4'd12: m_run <= (wr_data[1:0] == 2'b11);
          default: ;
        endcase
      end
      if (!en) begin
        cur <= pend;
        mpos <= 0; mcol <= 0; mf <= 0; ml <= 0;
        e_hs <= cur.pol[0]; e_vs <= cur.pol[1]; e_de <= cur.pol[2];
        e_disp <= 0; e_act <= 0; e_dv <= 0;
      end else begin
        automatic bit act = (mcol >= cur.ahs) && (mcol <= cur.ahe) &&
                            (mpos >= cur.avs) && (mpos <= cur.ave);
        automatic bit fe = (mpos == cur.fl - 1);
        automatic bit le = (mcol == cur.ll - 1);
        automatic bit clr = wr_en && (wr_addr == 4'd13) && wr_data[31];
        e_hs   <= (mcol < cur.hs) ^ cur.pol[0];
        e_vs   <= (mpos < cur.vsl) ^ cur.pol[1];
        e_disp <= (mcol >= cur.dhs) && (mcol <= cur.dhe) &&
                  (mpos >= cur.dvs) && (mpos <= cur.dve);
        e_act  <= act;
        e_de   <= act ^ cur.pol[2];
        e_dv   <= act && (cur.den == 0 || (mcol >= cur.ths && mcol <= cur.the));
        mpos   <= fe ? 0 : mpos + 1;
        mcol   <= (fe || le) ? 0 : mcol + 1;
        if (fe) cur <= pend;
        if (clr) begin
          mf <= 0; ml <= 0;
        end else if (m_run) begin
          if (fe) begin mf <= (mf + 1) & 16'hffff; ml <= 0; end
          else if (le) ml <= ml + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", req, ctx, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1 hsync", 32'(hsync_o), 32'(e_hs));
      chk("R2 vsync", 32'(vsync_o), 32'(e_vs));
      chk("R3 display window", 32'(disp_win_o), 32'(e_disp));
      chk("R4 active window", 32'(act_win_o), 32'(e_act));
      chk("R4 R5 data enable", 32'(de_o), 32'(e_de));
      chk("R6 data valid", 32'(data_vld_o), 32'(e_dv));
      chk("R7 frame count", 32'(frame_cnt_o), 32'(mf));
      chk("R7 line count", 32'(line_cnt_o), 32'(ml));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pos(input int p);
    @(negedge clk);
    while (mpos != p) @(negedge clk);
  endtask

  // 16-clock line, 12 lines, skew 1, 192-clock frame
  task automatic program_base();
    wr(0, {16'd16, 16'd2});
    wr(1, 32'd192);
    wr(2, 32'd32);
    wr(3, {16'd12, 16'd5});
    wr(4, 32'd65);
    wr(5, 32'd160);
    wr(6, {16'd12, 16'd5});
    wr(7, 32'd65);
    wr(8, 32'd144);
    wr(9, {16'd8, 16'd5});
    wr(10, 32'd0);
    wr(11, 32'd0);
    wr(12, 32'd3);
  endtask

  task automatic t_reset();
    ctx = "R11 reset";
    run(3);
    chk("R11 hsync", 32'(hsync_o), 0);
    chk("R11 vsync", 32'(vsync_o), 0);
    chk("R11 de", 32'(de_o), 0);
    chk("R11 windows", 32'({disp_win_o, act_win_o, data_vld_o}), 0);
    chk("R11 counters", {frame_cnt_o, line_cnt_o}, 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    run(2);
  endtask

  task automatic t_basic();
    ctx = "R1 R2 R3 R4 R7 base timing";
    program_base();
    run(2);
    en = 1'b1;
    run(2 * 192 + 20);
    chk("R7 frames after two wraps", 32'(frame_cnt_o), 32'd2);
  endtask

  task automatic t_pol_data();
    ctx = "R5 R6 inverted polarity, data window";
    en = 1'b0;
    wr(10, 32'd7);
    wr(11, 32'd1);
    run(2);
    en = 1'b1;
    run(192 + 30);
  endtask

  task automatic t_disable();
    ctx = "R9 disable";
    en = 1'b0;
    @(negedge clk);
    chk("R9 idle hsync at inverted level", 32'(hsync_o), 1);
    chk("R9 idle vsync at inverted level", 32'(vsync_o), 1);
    chk("R9 idle de at inverted level", 32'(de_o), 1);
    chk("R9 idle counters", {frame_cnt_o, line_cnt_o}, 0);
    run(5);
    en = 1'b1;
    @(negedge clk);
    chk("R9 restart at column 0 hsync", 32'(hsync_o), 0);
    chk("R9 restart at position 0 vsync", 32'(vsync_o), 0);
    run(100);
  endtask

  task automatic t_cnt_gate();
    logic [15:0] f0, l0;
    ctx = "R7 counting gated";
    wr(12, 32'd1);
    f0 = frame_cnt_o; l0 = line_cnt_o;
    run(250);
    chk("R7 frame count held", 32'(frame_cnt_o), 32'(f0));
    chk("R7 line count held", 32'(line_cnt_o), 32'(l0));
    wr(12, 32'd3);
    run(220);
  endtask

  task automatic t_cnt_clear();
    ctx = "R8 counter clear";
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'h8000_0000;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 frame count cleared", 32'(frame_cnt_o), 0);
    chk("R8 line count cleared", 32'(line_cnt_o), 0);
    run(60);
  endtask

  task automatic t_shadow();
    ctx = "R10 frame-boundary update";
    wait_pos(100);
    wr(10, 32'd0);
    wr(0, {16'd16, 16'd4});
    wait_pos(177);
    chk("R10 old polarity kept in current frame", 32'(hsync_o), 0);
    wait_pos(1);
    chk("R10 new polarity at next frame", 32'(hsync_o), 1);
    wait_pos(3);
    chk("R10 new sync width at next frame", 32'(hsync_o), 1);
    run(200);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_pol_data();
    t_disable();
    t_cnt_gate();
    t_cnt_clear();
    t_shadow();
    chk_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule